// File: doc/BRIEF.md
# Oscillator Stabilization Delay Counter

This block holds back the internal bus clock until the oscillator has had time to settle. It runs on the raw oscillator clock and keeps a 13-bit counter. After a power-on reset, and again whenever the chip leaves stop mode, the bus clock enable stays low until the counter reaches a terminal count. The bus clock enable is the signal that lets the clock gating downstream pass the bus clocks.

Two delays are available when waking from stop. A short delay suits canned oscillators, and a long delay suits crystal oscillators. An option input selects between them, and its value is captured at the moment of the wake event. After power-on the long delay always applies.

Outside stop and power-on, the counter runs freely. An external reset does not disturb it. A small request path is also part of the block. When monitor mode is entered while the reset vector bytes read as erased, it raises an internal reset and drives the reset pin low for a fixed number of cycles.

Top module: `osc_settle_ctrl`

## Requirements
- R1: While `por_pulse` is high, at every edge `cnt_value` becomes 0, `bus_clk_en` becomes 0 and `rst_pin_low` becomes 0.
- R2: After `por_pulse` falls, `cnt_value` equals the number of rising edges since the release. `bus_clk_en` rises exactly at edge 4096, whatever the value of `short_opt`.
- R3: A `stop_req` pulse makes `cnt_value` 0 and `bus_clk_en` 0 at the next edge. The counter then holds at 0 until a wake event arrives.
- R4: A wake event while stopped with `short_opt`=1 starts a delay. In this mode `bus_clk_en` rises at the 32nd edge after the edge that sampled the wake, and `cnt_value` reads 32 at that point.
- R5: With `short_opt`=0 at the wake event, `bus_clk_en` rises at the 4096th edge after the wake edge.
- R6: `short_opt` is sampled only at the wake edge, so changing it during a delay leaves the delay length unchanged.
- R7: Once high, `bus_clk_en` stays high until the next `stop_req` or `por_pulse`. Wake inputs seen while running have no effect.
- R8: Outside stop and power-on, `cnt_value` rises by one each edge and wraps from 8191 to 0.
- R9: While running, `ext_rst_in` does not change `cnt_value` or `bus_clk_en`. While stopped, it acts as a wake event.
- R10: When `mon_entry` and `vec_erased` are high together, `rst_pin_low` is high for the next 4 edges and the counter keeps counting. `mon_entry` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| por_pulse | input | 1 | Power-on reset, active high, synchronous |
| ext_rst_in | input | 1 | External reset pin asserted, active high |
| stop_req | input | 1 | Stop-entry strobe, one cycle |
| wake_irq | input | 1 | Interrupt wake event |
| wake_brk | input | 1 | Break wake event |
| short_opt | input | 1 | 1 selects the 32-cycle wake delay, 0 selects 4096 cycles |
| mon_entry | input | 1 | Monitor mode entry strobe |
| vec_erased | input | 1 | Reset vector bytes read as 0xFF |
| bus_clk_en | output | 1 | Bus clock enable |
| cnt_value | output | 13 | Observable counter value |
| rst_pin_low | output | 1 | Drives the reset pin low |

## Verification
Every output comes from a register. The bench therefore drives each input on a falling edge and reads the result on the next falling edge, one rising edge later. Delays are counted in rising edges after the sampling edge. After a wake, the enable is due at exactly edge 32 or edge 4096, and the bench checks the cycle before it as well as the cycle itself. The reset pin pulse is due at edges 1 to 4 after the request, and the bench looks for it to be low again at edge 5.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
   typedef enum logic [1:0] {
      PH_RUN    = 2'd0,
      PH_SETTLE = 2'd1,
      PH_STOP   = 2'd2
   } phase_e;
endpackage

// File: rtl/stab_counter.sv
module stab_counter #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             hold,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (clr)        cnt <= '0;
      else if (!hold) cnt <= cnt + ONE;
   end
endmodule

// File: rtl/settle_seq.sv
module settle_seq
   import osc_settle_pkg::*;
#(
   parameter int CNT_W     = 13,
   parameter int SHORT_CYC = 32,
   parameter int LONG_CYC  = 4096
) (
   input  logic             clk,
   input  logic             por,
   input  logic             stop_req,
   input  logic             wake,
   input  logic             short_opt,
   input  logic [CNT_W-1:0] cnt,
   output phase_e           phase,
   output logic             bus_en
);
   localparam logic [CNT_W-1:0] SHORT_TC = CNT_W'(SHORT_CYC - 1);
   localparam logic [CNT_W-1:0] LONG_TC  = CNT_W'(LONG_CYC - 1);

   logic             lim_short;
   logic [CNT_W-1:0] tc;

   assign tc = lim_short ? SHORT_TC : LONG_TC;

   always_ff @(posedge clk) begin
      if (por) begin
         phase     <= PH_SETTLE;
         lim_short <= 1'b0;
         bus_en    <= 1'b0;
      end else if (stop_req) begin
         phase  <= PH_STOP;
         bus_en <= 1'b0;
      end else begin
         unique case (phase)
            PH_STOP: if (wake) begin
               phase     <= PH_SETTLE;
               lim_short <= short_opt;
            end
            PH_SETTLE: if (cnt == tc) begin
               phase  <= PH_RUN;
               bus_en <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
   parameter int RST_LEN = 4
) (
   input  logic clk,
   input  logic por,
   input  logic req,
   output logic pin_low
);
   generate
      if (RST_LEN == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (por) pin_low <= 1'b0;
            else     pin_low <= req;
         end
      end else begin : g_multi
         localparam int LW = $clog2(RST_LEN);
         localparam logic [LW-1:0] LOAD = LW'(RST_LEN - 1);
         logic [LW-1:0] left;
         always_ff @(posedge clk) begin
            if (por) begin
               pin_low <= 1'b0;
               left    <= '0;
            end else if (req) begin
               pin_low <= 1'b1;
               left    <= LOAD;
            end else if (left != '0) begin
               left <= left - LW'(1);
            end else begin
               pin_low <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/osc_settle_ctrl.sv
module osc_settle_ctrl
   import osc_settle_pkg::*;
#(
   parameter int CNT_W     = 13,
   parameter int SHORT_CYC = 32,
   parameter int LONG_CYC  = 4096,
   parameter int RST_LEN   = 4
) (
   input  logic             osc_clk,
   input  logic             por_pulse,
   input  logic             ext_rst_in,
   input  logic             stop_req,
   input  logic             wake_irq,
   input  logic             wake_brk,
   input  logic             short_opt,
   input  logic             mon_entry,
   input  logic             vec_erased,
   output logic             bus_clk_en,
   output logic [CNT_W-1:0] cnt_value,
   output logic             rst_pin_low
);
   generate
      if (SHORT_CYC < 1 || SHORT_CYC > LONG_CYC) begin : g_bad_short
         $error("SHORT_CYC must lie in 1..LONG_CYC");
      end
      if (LONG_CYC >= (1 << CNT_W)) begin : g_bad_long
         $error("LONG_CYC must fit in CNT_W bits");
      end
      if (RST_LEN < 1) begin : g_bad_rst
         $error("RST_LEN must be at least 1");
      end
   endgenerate

   phase_e phase;
   logic   int_req;
   logic   wake_any;
   logic   cnt_clr;
   logic   cnt_hold;

   assign int_req  = mon_entry & vec_erased;
   assign wake_any = wake_irq | wake_brk | ext_rst_in | int_req;
   assign cnt_clr  = por_pulse | stop_req;
   assign cnt_hold = (phase == PH_STOP);

   stab_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (osc_clk),
      .clr  (cnt_clr),
      .hold (cnt_hold),
      .cnt  (cnt_value)
   );

   settle_seq #(
      .CNT_W     (CNT_W),
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC)
   ) u_seq (
      .clk       (osc_clk),
      .por       (por_pulse),
      .stop_req  (stop_req),
      .wake      (wake_any),
      .short_opt (short_opt),
      .cnt       (cnt_value),
      .phase     (phase),
      .bus_en    (bus_clk_en)
   );

   rst_stretch #(.RST_LEN(RST_LEN)) u_rst (
      .clk     (osc_clk),
      .por     (por_pulse),
      .req     (int_req),
      .pin_low (rst_pin_low)
   );
endmodule

// File: rtl/osc_settle_chk.sv
module osc_settle_chk #(
   parameter int CNT_W     = 13,
   parameter int SHORT_CYC = 32,
   parameter int LONG_CYC  = 4096
) (
   input logic             osc_clk,
   input logic             por_pulse,
   input logic             stop_req,
   input logic             mon_entry,
   input logic             vec_erased,
   input logic             bus_clk_en,
   input logic [CNT_W-1:0] cnt_value,
   input logic             rst_pin_low
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   a_r3_stop_clears: assert property (@(posedge osc_clk) disable iff (por_pulse)
      stop_req |=> (cnt_value == '0) && !bus_clk_en);

   a_r4_rise_at_limit: assert property (@(posedge osc_clk) disable iff (por_pulse)
      $rose(bus_clk_en) |-> (cnt_value == CNT_W'(SHORT_CYC) || cnt_value == CNT_W'(LONG_CYC)));

   a_r7_enable_holds: assert property (@(posedge osc_clk) disable iff (por_pulse)
      (bus_clk_en && !stop_req) |=> bus_clk_en);

   a_r8_free_run: assert property (@(posedge osc_clk) disable iff (por_pulse)
      (bus_clk_en && !stop_req) |=> (cnt_value == $past(cnt_value) + ONE));

   a_r10_pin_low: assert property (@(posedge osc_clk) disable iff (por_pulse)
      (mon_entry && vec_erased) |=> rst_pin_low);
endmodule

bind osc_settle_ctrl osc_settle_chk #(
   .CNT_W     (CNT_W),
   .SHORT_CYC (SHORT_CYC),
   .LONG_CYC  (LONG_CYC)
) u_chk (
   .osc_clk     (osc_clk),
   .por_pulse   (por_pulse),
   .stop_req    (stop_req),
   .mon_entry   (mon_entry),
   .vec_erased  (vec_erased),
   .bus_clk_en  (bus_clk_en),
   .cnt_value   (cnt_value),
   .rst_pin_low (rst_pin_low)
);

// File: tb/osc_settle_ctrl_tb.sv
module osc_settle_ctrl_tb_top;
   localparam time CLK_PER = 10ns;
   localparam int  SHORT_D = 32;
   localparam int  LONG_D  = 4096;

   logic        clk = 1'b0;
   logic        por = 1'b1;
   logic        ext_rst = 1'b0;
   logic        stop = 1'b0;
   logic        w_irq = 1'b0;
   logic        w_brk = 1'b0;
   logic        sopt = 1'b0;
   logic        mon = 1'b0;
   logic        erased = 1'b0;
   logic        en;
   logic [12:0] cnt;
   logic        pin;

   int n_chk  = 0;
   int n_fail = 0;
   int snap;

   always #(CLK_PER/2) clk = ~clk;

   osc_settle_ctrl dut_i (
      .osc_clk(clk), .por_pulse(por), .ext_rst_in(ext_rst), .stop_req(stop),
      .wake_irq(w_irq), .wake_brk(w_brk), .short_opt(sopt), .mon_entry(mon),
      .vec_erased(erased), .bus_clk_en(en), .cnt_value(cnt), .rst_pin_low(pin)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic do_stop;
      stop = 1'b1; step(1); stop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      step(3);
      chk("R1", "cnt in por", int'(cnt), 0);
      chk("R1", "en in por", int'(en), 0);
      chk("R1", "pin in por", int'(pin), 0);

      // R2: power-on uses the long delay even with short_opt=1
      sopt = 1'b1;
      por = 1'b0;
      step(LONG_D - 1);
      chk("R2", "en before limit", int'(en), 0);
      chk("R2", "cnt before limit", int'(cnt), LONG_D - 1);
      step(1);
      chk("R2", "en at limit", int'(en), 1);
      chk("R2", "cnt at limit", int'(cnt), LONG_D);

      // R7: wake while running is ignored
      w_irq = 1'b1; step(1); w_irq = 1'b0;
      chk("R7", "en after wake in run", int'(en), 1);
      chk("R7", "cnt after wake in run", int'(cnt), LONG_D + 1);

      // R9: external reset while running leaves the counter alone
      ext_rst = 1'b1; step(3); ext_rst = 1'b0;
      chk("R9", "cnt across ext reset", int'(cnt), LONG_D + 4);
      chk("R9", "en across ext reset", int'(en), 1);

      // R8: wrap from 8191 to 0
      step(8191 - (LONG_D + 4));
      chk("R8", "cnt top", int'(cnt), 8191);
      step(1);
      chk("R8", "cnt wrapped", int'(cnt), 0);

      // R3: stop entry
      do_stop();
      chk("R3", "cnt after stop", int'(cnt), 0);
      chk("R3", "en after stop", int'(en), 0);
      step(10);
      chk("R3", "cnt held in stop", int'(cnt), 0);
      chk("R3", "en held in stop", int'(en), 0);

      // R4 and R6: short wake, option dropped during the delay
      sopt = 1'b1;
      w_irq = 1'b1; step(1); w_irq = 1'b0;
      sopt = 1'b0;
      chk("R4", "cnt at wake", int'(cnt), 0);
      step(SHORT_D - 1);
      chk("R4", "en before short limit", int'(en), 0);
      step(1);
      chk("R6", "en at short limit", int'(en), 1);
      chk("R4", "cnt at short limit", int'(cnt), SHORT_D);

      // R5 and R6: long wake via break, option raised during the delay
      do_stop();
      sopt = 1'b0;
      w_brk = 1'b1; step(1); w_brk = 1'b0;
      sopt = 1'b1;
      step(SHORT_D);
      chk("R6", "en ignores late option", int'(en), 0);
      step(LONG_D - 1 - SHORT_D);
      chk("R5", "en before long limit", int'(en), 0);
      step(1);
      chk("R5", "en at long limit", int'(en), 1);
      chk("R5", "cnt at long limit", int'(cnt), LONG_D);

      // R9: external reset wakes from stop
      do_stop();
      sopt = 1'b1;
      step(2);
      chk("R9", "still stopped", int'(en), 0);
      ext_rst = 1'b1; step(1); ext_rst = 1'b0;
      step(SHORT_D);
      chk("R9", "en after ext wake", int'(en), 1);

      // R10: internal reset request
      mon = 1'b1; step(1); mon = 1'b0;
      chk("R10", "pin with mon only", int'(pin), 0);
      snap = int'(cnt);
      mon = 1'b1; erased = 1'b1; step(1); mon = 1'b0; erased = 1'b0;
      chk("R10", "pin edge 1", int'(pin), 1);
      step(3);
      chk("R10", "pin edge 4", int'(pin), 1);
      step(1);
      chk("R10", "pin edge 5", int'(pin), 0);
      chk("R10", "cnt kept counting", int'(cnt), snap + 5);
      chk("R10", "en kept", int'(en), 1);

      // R1: power-on in the middle of a run
      por = 1'b1; step(1);
      chk("R1", "cnt after late por", int'(cnt), 0);
      chk("R1", "en after late por", int'(en), 0);
      por = 1'b0;
      summary();
   end
endmodule